// File: doc/BRIEF.md
# Packet Destination ID Filter

This block decides, one cycle after a packet header arrives, what a two-layer serial receiver does with that packet. The header carries a two-bit transport-type code, a destination ID, a maintenance flag and a valid strobe. The first stage stands for the physical layer. It answers maintenance requests addressed to this node itself. It hands other packets to the logical layer, or it discards them. The second stage stands for the logical layer. It keeps a packet for local delivery, sends it on through the forwarding path, or discards it without any reply.

Software sets the configuration inputs. These are a node base ID, a unicast device ID, a multicast ID and an inclusive forwarding window, each given in a 16-bit and an 8-bit version, plus one mode bit called pass-all. When pass-all is clear, the physical stage does the destination check against the base ID. When pass-all is set, the physical stage passes every non-maintenance packet, and the logical stage alone decides the packet's fate from the unicast, multicast and window checks. Maintenance packets are always checked against the base ID, whatever the mode. The result appears as exactly one of four single-cycle pulses.

Top module: `hdr_dest_filter`

## Requirements
- R1: A maintenance header whose destination ID equals the base ID gives a maint_service pulse, with pass-all clear or set.
- R2: A maintenance header whose destination ID differs from the base ID gives a drop pulse, even when the ID matches the device, multicast or forwarding configuration.
- R3: With pass-all clear, a non-maintenance header whose destination ID differs from the base ID gives a drop pulse, even when the ID matches the multicast ID or lies in the forwarding window.
- R4: With pass-all set, every non-maintenance header of a legal transport type reaches the logical stage, whatever its destination ID.
- R5: At the logical stage, a destination ID equal to the device ID or to the multicast ID gives an accept pulse.
- R6: At the logical stage, a destination ID with lo <= ID <= hi gives a forward pulse, both bounds included. An ID that qualifies for both accept and forward is accepted.
- R7: At the logical stage, any other destination ID gives a drop pulse.
- R8: Transport type 2'b01 compares all 16 bits of the destination ID with the 16-bit registers. Type 2'b00 compares dest[7:0] with the 8-bit registers and ignores dest[15:8]. Types 2'b10 and 2'b11 always give drop.
- R9: Every header accepted while hdr_valid is high gives exactly one of maint_service, accept, forward or drop, high for the single cycle after the valid cycle. No output is high in a cycle that follows a cycle without hdr_valid.
- R10: While reset is held, and in the first cycle after it, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hdr_valid | input | 1 | Header present this cycle |
| hdr_tt | input | 2 | Transport type: 00 = 8-bit IDs, 01 = 16-bit IDs |
| hdr_dest | input | 16 | Destination ID (low 8 bits used for 8-bit type) |
| hdr_maint | input | 1 | Header is a maintenance request |
| cfg_pass_all | input | 1 | Move the destination check to the logical stage |
| cfg_base_wide | input | 16 | Node base ID, 16-bit |
| cfg_dev_wide | input | 16 | Unicast device ID, 16-bit |
| cfg_mcast_wide | input | 16 | Multicast ID, 16-bit |
| cfg_fwd_lo_wide | input | 16 | Forwarding window low bound, 16-bit |
| cfg_fwd_hi_wide | input | 16 | Forwarding window high bound, 16-bit |
| cfg_base_narrow | input | 8 | Node base ID, 8-bit |
| cfg_dev_narrow | input | 8 | Unicast device ID, 8-bit |
| cfg_mcast_narrow | input | 8 | Multicast ID, 8-bit |
| cfg_fwd_lo_narrow | input | 8 | Forwarding window low bound, 8-bit |
| cfg_fwd_hi_narrow | input | 8 | Forwarding window high bound, 8-bit |
| maint_service | output | 1 | Pulse: maintenance request answered locally |
| accept | output | 1 | Pulse: packet delivered locally |
| forward | output | 1 | Pulse: packet sent to the forwarding path |
| drop | output | 1 | Pulse: packet discarded |

## Verification
The same destination IDs are sent with pass-all clear and then set. A multicast or in-window ID changes its verdict between the two runs, which shows which stage did the check. Each ID is also sent as a maintenance header, which separates the base-ID service path from the logical path. Window tests use the two bounds and the IDs one below and one above them. An ID inside the window that also equals the device ID shows the priority of accept over forward. Eight-bit headers carry varied upper bits, and 8-bit register values are sent under the 16-bit type, so a wrong width selection shows up. Back-to-back and idle cycles check that each valid header gives exactly one pulse, and that nothing else does.

// File: rtl/dfilt_pkg.sv
package dfilt_pkg;

    localparam logic [1:0] TT_SMALL = 2'b00;
    localparam logic [1:0] TT_LARGE = 2'b01;

    typedef enum logic [1:0] {
        IDSZ_NARROW,
        IDSZ_WIDE,
        IDSZ_ILLEGAL
    } id_size_e;

    typedef enum logic [1:0] {
        PHY_DISCARD,
        PHY_SERVICE,
        PHY_HANDOFF
    } phy_fate_e;

    typedef enum logic [1:0] {
        LOG_DISCARD,
        LOG_LOCAL,
        LOG_ONWARD
    } log_fate_e;

    typedef struct packed {
        logic service;
        logic local_hit;
        logic onward;
        logic discard;
    } verdict_t;

endpackage

// File: rtl/dfilt_id_sel.sv
module dfilt_id_sel
    import dfilt_pkg::*;
#(
    parameter int WIDE_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic [1:0]          tt,
    input  logic [WIDE_W-1:0]   dest_raw,
    input  logic [WIDE_W-1:0]   base_w,
    input  logic [WIDE_W-1:0]   dev_w,
    input  logic [WIDE_W-1:0]   mcast_w,
    input  logic [WIDE_W-1:0]   lo_w,
    input  logic [WIDE_W-1:0]   hi_w,
    input  logic [NARROW_W-1:0] base_n,
    input  logic [NARROW_W-1:0] dev_n,
    input  logic [NARROW_W-1:0] mcast_n,
    input  logic [NARROW_W-1:0] lo_n,
    input  logic [NARROW_W-1:0] hi_n,
    output id_size_e            size,
    output logic [WIDE_W-1:0]   dest_sel,
    output logic [WIDE_W-1:0]   base_sel,
    output logic [WIDE_W-1:0]   dev_sel,
    output logic [WIDE_W-1:0]   mcast_sel,
    output logic [WIDE_W-1:0]   lo_sel,
    output logic [WIDE_W-1:0]   hi_sel
);

    localparam int PAD_W = WIDE_W - NARROW_W;

    function automatic logic [WIDE_W-1:0] widen(input logic [NARROW_W-1:0] v);
        return {{PAD_W{1'b0}}, v};
    endfunction

    always_comb begin
        case (tt)
            TT_SMALL: size = IDSZ_NARROW;
            TT_LARGE: size = IDSZ_WIDE;
            default:  size = IDSZ_ILLEGAL;
        endcase
    end

    always_comb begin
        if (size == IDSZ_NARROW) begin
            dest_sel  = widen(dest_raw[NARROW_W-1:0]);
            base_sel  = widen(base_n);
            dev_sel   = widen(dev_n);
            mcast_sel = widen(mcast_n);
            lo_sel    = widen(lo_n);
            hi_sel    = widen(hi_n);
        end else begin
            dest_sel  = dest_raw;
            base_sel  = base_w;
            dev_sel   = dev_w;
            mcast_sel = mcast_w;
            lo_sel    = lo_w;
            hi_sel    = hi_w;
        end
    end

endmodule

// File: rtl/dfilt_phys_stage.sv
module dfilt_phys_stage
    import dfilt_pkg::*;
#(
    parameter int WIDE_W = 16
) (
    input  id_size_e          size,
    input  logic              maint,
    input  logic              pass_all,
    input  logic [WIDE_W-1:0] dest,
    input  logic [WIDE_W-1:0] base,
    output phy_fate_e         fate
);

    logic base_hit;

    assign base_hit = (dest == base);

    always_comb begin
        if (size == IDSZ_ILLEGAL) begin
            fate = PHY_DISCARD;
        end else if (maint) begin
            fate = base_hit ? PHY_SERVICE : PHY_DISCARD;
        end else if (pass_all || base_hit) begin
            fate = PHY_HANDOFF;
        end else begin
            fate = PHY_DISCARD;
        end
    end

endmodule

// File: rtl/dfilt_logic_stage.sv
module dfilt_logic_stage
    import dfilt_pkg::*;
#(
    parameter int WIDE_W = 16
) (
    input  logic [WIDE_W-1:0] dest,
    input  logic [WIDE_W-1:0] dev,
    input  logic [WIDE_W-1:0] mcast,
    input  logic [WIDE_W-1:0] lo,
    input  logic [WIDE_W-1:0] hi,
    output log_fate_e         fate
);

    logic own_hit;
    logic in_window;

    assign own_hit   = (dest == dev) || (dest == mcast);
    assign in_window = (dest >= lo) && (dest <= hi);

    always_comb begin
        if (own_hit) begin
            fate = LOG_LOCAL;
        end else if (in_window) begin
            fate = LOG_ONWARD;
        end else begin
            fate = LOG_DISCARD;
        end
    end

endmodule

// File: rtl/hdr_dest_filter.sv
module hdr_dest_filter
    import dfilt_pkg::*;
#(
    parameter int WIDE_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hdr_valid,
    input  logic [1:0]          hdr_tt,
    input  logic [WIDE_W-1:0]   hdr_dest,
    input  logic                hdr_maint,
    input  logic                cfg_pass_all,
    input  logic [WIDE_W-1:0]   cfg_base_wide,
    input  logic [WIDE_W-1:0]   cfg_dev_wide,
    input  logic [WIDE_W-1:0]   cfg_mcast_wide,
    input  logic [WIDE_W-1:0]   cfg_fwd_lo_wide,
    input  logic [WIDE_W-1:0]   cfg_fwd_hi_wide,
    input  logic [NARROW_W-1:0] cfg_base_narrow,
    input  logic [NARROW_W-1:0] cfg_dev_narrow,
    input  logic [NARROW_W-1:0] cfg_mcast_narrow,
    input  logic [NARROW_W-1:0] cfg_fwd_lo_narrow,
    input  logic [NARROW_W-1:0] cfg_fwd_hi_narrow,
    output logic                maint_service,
    output logic                accept,
    output logic                forward,
    output logic                drop
);

    id_size_e          size;
    logic [WIDE_W-1:0] dest_sel, base_sel, dev_sel, mcast_sel, lo_sel, hi_sel;
    phy_fate_e         phy_fate;
    log_fate_e         log_fate;
    verdict_t          verdict_d, verdict_q;

    dfilt_id_sel #(
        .WIDE_W   (WIDE_W),
        .NARROW_W (NARROW_W)
    ) i_id_sel (
        .tt        (hdr_tt),
        .dest_raw  (hdr_dest),
        .base_w    (cfg_base_wide),
        .dev_w     (cfg_dev_wide),
        .mcast_w   (cfg_mcast_wide),
        .lo_w      (cfg_fwd_lo_wide),
        .hi_w      (cfg_fwd_hi_wide),
        .base_n    (cfg_base_narrow),
        .dev_n     (cfg_dev_narrow),
        .mcast_n   (cfg_mcast_narrow),
        .lo_n      (cfg_fwd_lo_narrow),
        .hi_n      (cfg_fwd_hi_narrow),
        .size      (size),
        .dest_sel  (dest_sel),
        .base_sel  (base_sel),
        .dev_sel   (dev_sel),
        .mcast_sel (mcast_sel),
        .lo_sel    (lo_sel),
        .hi_sel    (hi_sel)
    );

    dfilt_phys_stage #(
        .WIDE_W (WIDE_W)
    ) i_phys (
        .size     (size),
        .maint    (hdr_maint),
        .pass_all (cfg_pass_all),
        .dest     (dest_sel),
        .base     (base_sel),
        .fate     (phy_fate)
    );

    dfilt_logic_stage #(
        .WIDE_W (WIDE_W)
    ) i_logic (
        .dest  (dest_sel),
        .dev   (dev_sel),
        .mcast (mcast_sel),
        .lo    (lo_sel),
        .hi    (hi_sel),
        .fate  (log_fate)
    );

    always_comb begin
        verdict_d = '0;
        if (hdr_valid) begin
            case (phy_fate)
                PHY_SERVICE: verdict_d.service = 1'b1;
                PHY_HANDOFF: begin
                    case (log_fate)
                        LOG_LOCAL:  verdict_d.local_hit = 1'b1;
                        LOG_ONWARD: verdict_d.onward    = 1'b1;
                        default:    verdict_d.discard   = 1'b1;
                    endcase
                end
                default: verdict_d.discard = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            verdict_q <= '0;
        end else begin
            verdict_q <= verdict_d;
        end
    end

    assign maint_service = verdict_q.service;
    assign accept        = verdict_q.local_hit;
    assign forward       = verdict_q.onward;
    assign drop          = verdict_q.discard;

    // R9
    out_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({maint_service, accept, forward, drop}));

    // R9
    pulse_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> $countones({maint_service, accept, forward, drop}) == 1);

    // R9
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> !(maint_service || accept || forward || drop));

    // R1
    service_needs_maint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        maint_service |-> $past(hdr_maint));

    // R2
    logic_path_nonmaint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept || forward) |-> !$past(hdr_maint));

    // R3
    strict_mode_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && !cfg_pass_all && !hdr_maint && hdr_tt == TT_LARGE
         && hdr_dest != cfg_base_wide) |=> drop);

    // R8
    bad_tt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_tt[1]) |=> drop);

endmodule

// File: tb/test_hdr_dest_filter.sv
module test_hdr_dest_filter;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        hdr_valid;
    logic [1:0]  hdr_tt;
    logic [15:0] hdr_dest;
    logic        hdr_maint;
    logic        cfg_pass_all;
    logic [15:0] cfg_base_wide, cfg_dev_wide, cfg_mcast_wide, cfg_fwd_lo_wide, cfg_fwd_hi_wide;
    logic [7:0]  cfg_base_narrow, cfg_dev_narrow, cfg_mcast_narrow, cfg_fwd_lo_narrow, cfg_fwd_hi_narrow;
    logic        maint_service, accept, forward, drop;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    hdr_dest_filter i_hdr_dest_filter (
        .clk               (clk),
        .rst_n             (rst_n),
        .hdr_valid         (hdr_valid),
        .hdr_tt            (hdr_tt),
        .hdr_dest          (hdr_dest),
        .hdr_maint         (hdr_maint),
        .cfg_pass_all      (cfg_pass_all),
        .cfg_base_wide     (cfg_base_wide),
        .cfg_dev_wide      (cfg_dev_wide),
        .cfg_mcast_wide    (cfg_mcast_wide),
        .cfg_fwd_lo_wide   (cfg_fwd_lo_wide),
        .cfg_fwd_hi_wide   (cfg_fwd_hi_wide),
        .cfg_base_narrow   (cfg_base_narrow),
        .cfg_dev_narrow    (cfg_dev_narrow),
        .cfg_mcast_narrow  (cfg_mcast_narrow),
        .cfg_fwd_lo_narrow (cfg_fwd_lo_narrow),
        .cfg_fwd_hi_narrow (cfg_fwd_hi_narrow),
        .maint_service     (maint_service),
        .accept            (accept),
        .forward           (forward),
        .drop              (drop)
    );

    // vector: {pass_all, maint, tt[1:0], dest[15:0], expect[1:0], req[3:0]}
    // expect: 0 service, 1 accept, 2 forward, 3 drop
    localparam int NVEC = 21;
    localparam logic [25:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 2'b01, 16'h0001, 2'd0, 4'd1},  // R1 maint to base, strict
        {1'b1, 1'b1, 2'b01, 16'h0001, 2'd0, 4'd1},  // R1 maint to base, pass-all
        {1'b0, 1'b1, 2'b01, 16'h0002, 2'd3, 4'd2},  // R2 maint elsewhere
        {1'b1, 1'b1, 2'b01, 16'h00F0, 2'd3, 4'd2},  // R2 maint to multicast
        {1'b0, 1'b0, 2'b01, 16'h0001, 2'd1, 4'd5},  // R5 unicast in strict mode
        {1'b0, 1'b0, 2'b01, 16'h00F0, 2'd3, 4'd3},  // R3 multicast blocked in strict mode
        {1'b0, 1'b0, 2'b01, 16'h0150, 2'd3, 4'd3},  // R3 window blocked in strict mode
        {1'b1, 1'b0, 2'b01, 16'h00F0, 2'd1, 4'd4},  // R4 multicast reaches logic
        {1'b1, 1'b0, 2'b01, 16'h0100, 2'd2, 4'd6},  // R6 low bound
        {1'b1, 1'b0, 2'b01, 16'h01FF, 2'd2, 4'd6},  // R6 high bound
        {1'b1, 1'b0, 2'b01, 16'h00FF, 2'd3, 4'd7},  // R7 below window
        {1'b1, 1'b0, 2'b01, 16'h0200, 2'd3, 4'd7},  // R7 above window
        {1'b1, 1'b0, 2'b00, 16'hAB11, 2'd1, 4'd8},  // R8 narrow, upper bits ignored
        {1'b0, 1'b1, 2'b00, 16'hFF11, 2'd0, 4'd8},  // R8 narrow maint to base
        {1'b1, 1'b0, 2'b00, 16'h0033, 2'd1, 4'd8},  // R8 narrow multicast
        {1'b1, 1'b0, 2'b00, 16'h004F, 2'd2, 4'd8},  // R8 narrow window top
        {1'b1, 1'b0, 2'b00, 16'h0050, 2'd3, 4'd8},  // R8 narrow past window
        {1'b1, 1'b0, 2'b01, 16'h0011, 2'd3, 4'd8},  // R8 narrow value under wide type
        {1'b1, 1'b1, 2'b10, 16'h0001, 2'd3, 4'd8},  // R8 illegal type 10
        {1'b1, 1'b0, 2'b11, 16'h0001, 2'd3, 4'd8},  // R8 illegal type 11
        {1'b0, 1'b0, 2'b00, 16'h0033, 2'd3, 4'd3}   // R3 narrow multicast, strict mode
    };

    function automatic logic [3:0] code_bits(input logic [1:0] c);
        case (c)
            2'd0:    return 4'b1000;
            2'd1:    return 4'b0100;
            2'd2:    return 4'b0010;
            default: return 4'b0001;
        endcase
    endfunction

    task automatic check_bits(input logic [3:0] exp, input string tag);
        logic [3:0] got;
        got = {maint_service, accept, forward, drop};
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs {svc,acc,fwd,drp} = %b, expected %b", tag, got, exp);
        end
    endtask

    task automatic apply(input logic pa, input logic mt, input logic [1:0] tt, input logic [15:0] d);
        cfg_pass_all = pa;
        hdr_maint    = mt;
        hdr_tt       = tt;
        hdr_dest     = d;
        hdr_valid    = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n             = 1'b0;
        hdr_valid         = 1'b0;
        hdr_tt            = 2'b01;
        hdr_dest          = '0;
        hdr_maint         = 1'b0;
        cfg_pass_all      = 1'b0;
        cfg_base_wide     = 16'h0001;
        cfg_dev_wide      = 16'h0001;
        cfg_mcast_wide    = 16'h00F0;
        cfg_fwd_lo_wide   = 16'h0100;
        cfg_fwd_hi_wide   = 16'h01FF;
        cfg_base_narrow   = 8'h11;
        cfg_dev_narrow    = 8'h11;
        cfg_mcast_narrow  = 8'h33;
        cfg_fwd_lo_narrow = 8'h40;
        cfg_fwd_hi_narrow = 8'h4F;

        // R10: outputs low during reset, even with a header present
        repeat (2) @(negedge clk);
        apply(1'b0, 1'b1, 2'b01, 16'h0001);
        @(negedge clk);
        check_bits(4'b0000, "R10 during reset");
        hdr_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check_bits(4'b0000, "R10 after reset");

        // table walk: one header, check one cycle later, then idle
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][25], VEC[i][24], VEC[i][23:22], VEC[i][21:6]);
            @(negedge clk);
            hdr_valid = 1'b0;
            check_bits(code_bits(VEC[i][5:4]), $sformatf("R%0d vector %0d", VEC[i][3:0], i));
            @(negedge clk);
            check_bits(4'b0000, "R9 idle after vector");
        end

        // R6: accept takes priority over an overlapping window
        cfg_fwd_lo_wide = 16'h0000;
        cfg_fwd_hi_wide = 16'h0010;
        apply(1'b1, 1'b0, 2'b01, 16'h0001);
        @(negedge clk);
        hdr_valid = 1'b0;
        check_bits(4'b0100, "R6 accept over forward");
        apply(1'b1, 1'b0, 2'b01, 16'h0000);
        @(negedge clk);
        hdr_valid = 1'b0;
        check_bits(4'b0010, "R6 window at zero");
        cfg_fwd_lo_wide = 16'h0100;
        cfg_fwd_hi_wide = 16'h01FF;

        // R9: back-to-back headers each give their own pulse
        apply(1'b1, 1'b0, 2'b01, 16'h0180);
        @(negedge clk);
        check_bits(4'b0010, "R9 first of burst");
        apply(1'b1, 1'b1, 2'b01, 16'h0001);
        @(negedge clk);
        check_bits(4'b1000, "R9 second of burst");
        apply(1'b1, 1'b0, 2'b01, 16'h7777);
        @(negedge clk);
        hdr_valid = 1'b0;
        check_bits(4'b0001, "R9 third of burst");
        @(negedge clk);
        check_bits(4'b0000, "R9 quiet after burst");

        // R9: header fields change while valid is low give nothing
        hdr_maint = 1'b1;
        hdr_dest  = 16'h0001;
        @(negedge clk);
        check_bits(4'b0000, "R9 no valid no pulse");

        // R10: reset in mid-flight clears a pending pulse
        apply(1'b1, 1'b0, 2'b01, 16'h0001);
        @(negedge clk);
        hdr_valid = 1'b0;
        rst_n = 1'b0;
        #1;
        check_bits(4'b0000, "R10 reset clears pulse");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_bits(4'b0000, "R10 quiet after second reset");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule